// File: doc/BRIEF.md
# Interrupt Priority Register Bank

This block is the storage for interrupt priorities. Each interrupt has one 8-bit priority field, and four fields share each 32-bit word. A simple register bus reads and writes the words, with a byte-enable vector to select the lanes. Only the upper `PRIO_BITS` bits of each field are kept. The lower bits always read as zero, so software can learn how many bits exist by writing all ones and reading the value back. The same mask applies to every lane of every word.

The bus uses byte addresses. Bits `[1:0]` of the address do not move data: a read always returns the whole addressed word, with lane n in bits `8n+7:8n`, and the requester takes the byte it wants. A word whose byte offset is at or above `NUM_IRQ` is unimplemented. It reads as zero, and writes to it are dropped. Read data is registered, and it appears one cycle after the read request. This block does not use the priorities for arbitration.

Top module: `prio_reg_bank`

## Requirements
- R1: After reset every stored field is zero. `bus_rdata` is zero, and a read of any word returns zero.
- R2: A write with all four byte enables set stores the four lanes independently. A read issued on a later cycle returns the stored word in `bus_rdata` one cycle after `bus_rd`.
- R3: Only the upper `PRIO_BITS` bits of each lane are stored, and the lower `8-PRIO_BITS` bits of every lane read as zero. With the default of 5 bits, writing 0xFFFFFFFF reads back as 0xF8F8F8F8.
- R4: Enable bit `bus_be[n]` qualifies lane n, which is bits `8n+7:8n`. Lanes whose enable bit is clear keep their value, and a write with no enables set changes nothing.
- R5: Address bits `[1:0]` do not affect which word is accessed or where lanes sit. A read at byte offset 4k+j returns the same word as a read at 4k.
- R6: A read of a word at byte offset `NUM_IRQ` or above returns zero.
- R7: A write to a word at byte offset `NUM_IRQ` or above changes no implemented word.
- R8: The last implemented word, at byte offset `NUM_IRQ-4`, is fully writable and readable, subject to the mask in R3.
- R9: When a read and a write address the same word in the same cycle, the read returns the contents from before the write. The next read returns the new contents.
- R10: `bus_rdata` holds its value on every cycle without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Per-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one cycle after `bus_rd` |

## Verification
A read and a write can hit the same word in the same cycle. The bench provokes this by asserting `bus_rd` and `bus_wr` together on one word with new data. It expects the pre-write contents in that response and the new contents in the following read. The same collision on an unimplemented word must return zero and must leave every implemented word unchanged, which the bench confirms by reading back all implemented words afterwards.

// File: rtl/prio_bank_pkg.sv
package prio_bank_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic             wr;
        logic             rd;
        logic [LANES-1:0] be;
        word_t            wdata;
    } bus_cmd_t;

    // Mask keeping the upper 'bits' bits of one lane
    function automatic lane_t lane_keep(input int bits);
        return lane_t'(8'hFF << (LANE_W - bits));
    endfunction

    function automatic word_t word_keep(input int bits);
        return {LANES{lane_keep(bits)}};
    endfunction

endpackage

// File: rtl/prio_addr_decode.sv
module prio_addr_decode
    import prio_bank_pkg::*;
#(
    parameter int IDX_W     = 6,
    parameter int NUM_WORDS = 8
) (
    input  logic [IDX_W-1:0]     word_idx,
    input  logic                 wr,
    output logic                 in_range,
    output logic [NUM_WORDS-1:0] wr_sel
);

    assign in_range = ({1'b0, word_idx} < (IDX_W+1)'(NUM_WORDS));

    always_comb begin
        wr_sel = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (wr && in_range && (word_idx == IDX_W'(i)))
                wr_sel[i] = 1'b1;
        end
    end

endmodule

// File: rtl/prio_word.sv
module prio_word
    import prio_bank_pkg::*;
#(
    parameter int PRIO_BITS = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [LANES-1:0] be,
    input  word_t            wdata,
    output word_t            q
);

    localparam lane_t KEEP = lane_keep(PRIO_BITS);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_t field;
        // Masked bits are constant zero, so their flops reduce away
        always_ff @(posedge clk) begin
            if (rst)
                field <= '0;
            else if (we && be[l])
                field <= wdata[l*LANE_W +: LANE_W] & KEEP;
        end
        assign q[l*LANE_W +: LANE_W] = field;
    end

endmodule

// File: rtl/prio_read_mux.sv
module prio_read_mux
    import prio_bank_pkg::*;
#(
    parameter int IDX_W     = 6,
    parameter int NUM_WORDS = 8
) (
    input  logic [NUM_WORDS*WORD_W-1:0] words,
    input  logic [IDX_W-1:0]            word_idx,
    input  logic                        in_range,
    output word_t                       sel
);

    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (in_range && (word_idx == IDX_W'(i)))
                sel = words[i*WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/prio_reg_bank.sv
module prio_reg_bank
    import prio_bank_pkg::*;
#(
    parameter int NUM_IRQ   = 32,
    parameter int PRIO_BITS = 5,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LANES-1:0]  bus_be,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata
);

    localparam int NUM_WORDS = NUM_IRQ / LANES;
    localparam int IDX_W     = ADDR_W - 2;

    bus_cmd_t                    cmd;
    logic [IDX_W-1:0]            word_idx;
    logic                        in_range;
    logic [NUM_WORDS-1:0]        wr_sel;
    logic [NUM_WORDS*WORD_W-1:0] words;
    word_t                       rd_word;
    word_t                       rdata_q;

    assign cmd      = '{wr: bus_wr, rd: bus_rd, be: bus_be, wdata: bus_wdata};
    assign word_idx = bus_addr[ADDR_W-1:2];

    prio_addr_decode #(.IDX_W(IDX_W), .NUM_WORDS(NUM_WORDS)) u_dec (
        .word_idx (word_idx),
        .wr       (cmd.wr),
        .in_range (in_range),
        .wr_sel   (wr_sel)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        prio_word #(.PRIO_BITS(PRIO_BITS)) u_word (
            .clk   (clk),
            .rst   (rst),
            .we    (wr_sel[w]),
            .be    (cmd.be),
            .wdata (cmd.wdata),
            .q     (words[w*WORD_W +: WORD_W])
        );
    end

    prio_read_mux #(.IDX_W(IDX_W), .NUM_WORDS(NUM_WORDS)) u_mux (
        .words    (words),
        .word_idx (word_idx),
        .in_range (in_range),
        .sel      (rd_word)
    );

    // Read data is captured from pre-edge storage: read-before-write
    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (cmd.rd)
            rdata_q <= rd_word;
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/prio_reg_bank_chk.sv
module prio_reg_bank_chk
    import prio_bank_pkg::*;
#(
    parameter int NUM_IRQ   = 32,
    parameter int PRIO_BITS = 5,
    parameter int ADDR_W    = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_rdata
);

    localparam word_t LOW_BITS = ~word_keep(PRIO_BITS);

    logic beyond;
    assign beyond = ({1'b0, bus_addr} >= (ADDR_W+1)'(NUM_IRQ));

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (bus_rdata == '0)); // R1

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata & LOW_BITS) == '0); // R3

    AST_BEYOND_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && beyond) |=> (bus_rdata == '0)); // R6

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata)); // R10

endmodule

bind prio_reg_bank prio_reg_bank_chk #(
    .NUM_IRQ   (NUM_IRQ),
    .PRIO_BITS (PRIO_BITS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/prio_reg_bank_tb_top.sv
module prio_reg_bank_tb_top;

    localparam int NI = 32;
    localparam int PB = 5;
    localparam int AW = 8;
    localparam int NW = NI / 4;
    localparam logic [7:0]  KEEP  = 8'(8'hFF << (8 - PB));
    localparam logic [31:0] WKEEP = {4{KEEP}};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [3:0]    bus_be = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [31:0] model [NW];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;

    always #5 clk = ~clk;

    prio_reg_bank #(.NUM_IRQ(NI), .PRIO_BITS(PB), .ADDR_W(AW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drives one bus cycle; updates the model and queues the expected read
    task automatic cycle(input bit wr, input bit rd, input int addr,
                         input logic [3:0] be, input logic [31:0] data, input string tag);
        int idx;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = AW'(addr); bus_be = be; bus_wdata = data;
        idx = addr / 4;
        if (rd) begin
            exp_q.push_back((addr < NI) ? model[idx] : 32'h0);
            tag_q.push_back(tag);
        end
        if (wr && addr < NI)
            for (int l = 0; l < 4; l++)
                if (be[l]) model[idx][l*8 +: 8] = data[l*8 +: 8] & KEEP;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    // Monitor: scoreboard compare one cycle after a read request
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0)
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end

    task automatic read_all(input string tag);
        for (int w = 0; w < NW; w++) cycle(0, 1, w*4, 4'h0, 32'h0, tag);
        idle();
    endtask

    initial begin
        logic [31:0] held;
        for (int w = 0; w < NW; w++) model[w] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rdata after reset", bus_rdata, 32'h0);
        read_all("R1 reset contents");

        cycle(1, 0, 0, 4'hF, 32'hFFFF_FFFF, "");
        cycle(0, 1, 0, 4'h0, 32'h0, "R3 all-ones mask");
        idle();
        check("R3 all-ones literal", model[0], 32'hF8F8_F8F8);

        cycle(1, 0, 4, 4'hF, 32'h1234_5678, "");
        cycle(0, 1, 4, 4'h0, 32'h0, "R2 word write");
        cycle(1, 0, 6, 4'b0100, 32'h00AB_0000, "");
        cycle(0, 1, 5, 4'h0, 32'h0, "R4 R5 lane2 write, offset read");
        cycle(1, 0, 4, 4'h0, 32'hFFFF_FFFF, "");
        cycle(0, 1, 7, 4'h0, 32'h0, "R4 no enables");
        cycle(1, 0, 8, 4'b1001, 32'hC3C3_C3C3, "");
        cycle(0, 1, 10, 4'h0, 32'h0, "R4 R5 lanes 0 and 3");

        cycle(1, 0, NI, 4'hF, 32'hFFFF_FFFF, "");
        cycle(1, 0, (1 << AW) - 4, 4'hF, 32'hFFFF_FFFF, "");
        cycle(0, 1, NI, 4'h0, 32'h0, "R6 first beyond");
        cycle(0, 1, (1 << AW) - 1, 4'h0, 32'h0, "R6 top address");
        idle();
        read_all("R7 beyond writes ignored");

        cycle(1, 0, NI - 4, 4'hF, 32'hA5A5_5A5A, "");
        cycle(0, 1, NI - 4, 4'h0, 32'h0, "R8 last word");
        idle();
        check("R8 last word literal", model[NW-1], 32'hA0A0_5858);

        cycle(1, 0, 12, 4'hF, 32'h1111_1111, "");
        cycle(1, 1, 12, 4'hF, 32'hF0E0_D0C8, "R9 collide returns old");
        cycle(0, 1, 12, 4'h0, 32'h0, "R9 next read returns new");
        cycle(1, 1, NI + 8, 4'hF, 32'hFFFF_FFFF, "R9 R6 collide beyond");
        idle();
        read_all("R9 R7 after beyond collide");

        cycle(0, 1, 4, 4'h0, 32'h0, "R10 setup");
        idle();
        @(negedge clk);
        held = bus_rdata;
        cycle(1, 0, 4, 4'hF, 32'h0, "");
        idle();
        repeat (2) @(negedge clk);
        check("R10 rdata held", bus_rdata, held);
        check("R2 queue drained", 32'(exp_q.size()), 32'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule